// File: doc/BRIEF.md
# Binary64 Multiply Post-Processor

This block is the final stage of a double-precision multiplier. Upstream logic has already formed the product significand: 53 bits with the leading one at the top, plus a guard bit and a sticky bit. It has also formed a signed, biased product exponent. This block takes those values together with the two raw operands, a rounding-mode code and a set of per-exception trap enables. It produces the packed 64-bit result, a per-operation trap-cause vector and accumulated exception flags.

The raw operands are used only to detect special inputs and to form the sign. NaN, infinity and zero operands bypass the rounding path. In that case the block picks the quiet NaN, the infinity, the signed zero or the invalid-operation response itself.

For finite products, the block does the following:
- It rounds in one of four modes.
- It detects overflow and underflow. With the matching trap enabled, it delivers the result with its exponent wrapped into range. Otherwise it saturates, or denormalizes and rounds again.
- It judges tininess after rounding.

All outputs are registered once.

Top module: `fpm_post`

## Requirements
- R1: The sign of every finite, infinite or zero result is the exclusive OR of the two operand sign bits (bit 63).
- R2: Infinity multiplied by zero, in either operand order, is invalid. With the invalid trap enabled, the block raises trap bit 3 and does not write the result (`result_wr_o` low). Otherwise it writes the positive quiet NaN 0x7FF8000000000000 and raises flag bit 3.
- R3: Mantissa bit 51 set marks a quiet NaN and clear marks a signaling one. Quieting sets bit 51. The block selects the NaN to return in this order:
  - a signaling NaN in operand A, returned quieted;
  - otherwise a signaling NaN in operand B, returned quieted;
  - otherwise the first NaN operand, returned unchanged.
  A signaling NaN raises invalid, either as a flag or as a trap when trapping is enabled. Infinity in A times a NaN in B returns B's NaN.
- R4: The rounding code is 0 for nearest-even, 1 for toward zero, 2 for toward +infinity and 3 for toward -infinity. Rounding applies only when guard or sticky is set and the exponent is above 0 or the underflow trap is enabled. Each mode increments as follows:
  - nearest-even: when guard is set and sticky or the LSB is set;
  - toward +infinity: only for positive results;
  - toward -infinity: only for negative results;
  - toward zero: never.
- R5: A rounding increment that carries out of the significand raises the exponent by one and leaves the fraction zero.
- R6: An exponent of 2047 or more after rounding is an overflow. With the overflow trap off, the block raises flag bits 2 and 0. The result is infinity for nearest-even, for toward +infinity when positive and for toward -infinity when negative; otherwise it is the largest finite magnitude, keeping the sign.
- R7: With the overflow trap on, an overflow writes the rounded result with its exponent reduced by 1536 (low 11 bits kept) and raises trap bit 2.
- R8: An exponent of 0 or less after rounding is an underflow. With the underflow trap on, the block writes the rounded result with its exponent raised by 1536 and raises trap bit 1.
- R9: With the underflow trap off, the unrounded significand is shifted right by 1 minus the exponent. The block then recomputes guard and sticky from the bits shifted out, including the previous guard and sticky, and rounds again. A carry into bit 52 makes the smallest normal number.
- R10: At an exponent of exactly 0 with an inexact product, a trial rounding that carries past the hidden bit marks the result as not tiny. The underflow flag (bit 1) is raised only when the result is tiny and the denormalized result is inexact.
- R11: An inexact result raises trap bit 0 when the inexact trap is enabled, or flag bit 0 otherwise. This applies to trapped overflow and underflow as well.
- R12: The flags use the same bit positions as the traps and enables: 3 invalid, 2 overflow, 1 underflow, 0 inexact. They accumulate across operations and return to zero only through `flag_clr_i`.
- R13: Results, traps and flags for an operation appear on the first rising edge after `in_valid_i` and are marked by `out_valid_o`. A zero operand yields a signed zero with no exception, whatever the product inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operation present this cycle |
| opa_i | input | 64 | Raw operand A |
| opb_i | input | 64 | Raw operand B |
| prod_sig_i | input | 53 | Product significand, leading one at bit 52 |
| prod_grd_i | input | 1 | Guard bit below the significand |
| prod_stk_i | input | 1 | OR of all lower product bits |
| prod_exp_i | input | 13 | Signed biased product exponent |
| rnd_mode_i | input | 2 | Rounding code (R4) |
| trap_en_i | input | 4 | Trap enables, bit order as in R12 |
| flag_clr_i | input | 1 | Clears the accumulated flags |
| out_valid_o | output | 1 | Result of an operation is present |
| result_o | output | 64 | Packed result, held when not written |
| result_wr_o | output | 1 | Result was written for this operation |
| trap_o | output | 4 | Trap causes of this operation |
| flags_o | output | 4 | Accumulated exception flags |

## Verification
Every result of this block is due exactly one rising edge after the cycle in which `in_valid_i` is high. The result word, the write strobe, the trap vector and the updated flag vector all become valid on that edge. The bench applies one operation per falling edge. It queues the expected outcome at that falling edge, including the flag value accumulated up to and including this operation. A falling-edge monitor compares against the queue whenever `out_valid_o` is high, so each comparison falls half a period after the edge that produced the result. A flag clear is checked on the falling edge after the single rising edge that applies it.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int EW      = 11;
    localparam int MW      = 52;
    localparam int SW      = MW + 1;
    localparam int DW      = 1 + EW + MW;
    localparam int XW      = EW + 2;
    localparam int FLG_W   = 4;
    localparam int EXP_MAX = (1 << EW) - 1;
    localparam int WRAP    = 3 << (EW - 2);

    localparam int FX_INX = 0;
    localparam int FX_UNF = 1;
    localparam int FX_OVF = 2;
    localparam int FX_INV = 3;

    localparam logic signed [XW-1:0] XEXP_TOP  = XW'(EXP_MAX);
    localparam logic signed [XW-1:0] XEXP_WRAP = XW'(WRAP);
    localparam logic signed [XW-1:0] XEXP_ZERO = '0;

    localparam logic [DW-1:0] QMASK      = DW'(1) << (MW - 1);
    localparam logic [DW-1:0] CANON_QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rmode_e;

    typedef struct packed {
        logic          sign;
        logic [XW-1:0] exp;
        logic [SW-1:0] sig;
        logic          grd;
        logic          stk;
    } fpm_prod_t;

    typedef struct packed {
        logic [DW-1:0]    bits;
        logic             wr;
        logic [FLG_W-1:0] trap;
        logic [FLG_W-1:0] flag;
    } fpm_out_t;

    function automatic logic round_up(rmode_e m, logic neg, logic lsb, logic g, logic s);
        case (m)
            RM_NEAR: return g & (s | lsb);
            RM_ZERO: return 1'b0;
            RM_UP:   return ~neg & (g | s);
            default: return neg & (g | s);
        endcase
    endfunction

    function automatic logic is_nan(logic [DW-1:0] x);
        return (&x[DW-2:MW]) & (|x[MW-1:0]);
    endfunction

    function automatic logic is_inf(logic [DW-1:0] x);
        return (&x[DW-2:MW]) & ~(|x[MW-1:0]);
    endfunction

    function automatic logic is_zero(logic [DW-1:0] x);
        return ~(|x[DW-2:0]);
    endfunction

    function automatic logic is_snan(logic [DW-1:0] x);
        return is_nan(x) & ~x[MW-1];
    endfunction

endpackage

// File: rtl/fpm_special.sv
module fpm_special
    import fpm_pkg::*;
(
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          inv_te,
    output logic          hit,
    output fpm_out_t      res
);
    logic a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_zero, b_zero, sgn;
    logic inv;
    logic [DW-1:0] val;

    assign a_nan  = is_nan(opa);
    assign b_nan  = is_nan(opb);
    assign a_snan = is_snan(opa);
    assign b_snan = is_snan(opb);
    assign a_inf  = is_inf(opa);
    assign b_inf  = is_inf(opb);
    assign a_zero = is_zero(opa);
    assign b_zero = is_zero(opb);
    assign sgn    = opa[DW-1] ^ opb[DW-1];

    // Selection order: NaN in A, NaN in B, invalid pair, infinity, zero.
    always_comb begin
        hit = 1'b1;
        inv = 1'b0;
        val = '0;
        if (a_nan) begin
            if (a_snan) begin
                inv = 1'b1;
                val = opa | QMASK;
            end else if (b_snan) begin
                inv = 1'b1;
                val = opb | QMASK;
            end else begin
                val = opa;
            end
        end else if (b_nan) begin
            inv = b_snan;
            val = opb | QMASK;
        end else if ((a_inf && b_zero) || (b_inf && a_zero)) begin
            inv = 1'b1;
            val = CANON_QNAN;
        end else if (a_inf || b_inf) begin
            val = {sgn, {EW{1'b1}}, {MW{1'b0}}};
        end else if (a_zero || b_zero) begin
            val = {sgn, {(DW-1){1'b0}}};
        end else begin
            hit = 1'b0;
        end
    end

    always_comb begin
        res              = '0;
        res.bits         = val;
        res.wr           = ~(inv & inv_te);
        res.trap[FX_INV] = inv & inv_te;
        res.flag[FX_INV] = inv & ~inv_te;
    end

endmodule

// File: rtl/fpm_denorm.sv
module fpm_denorm
    import fpm_pkg::*;
(
    input  fpm_prod_t      p,
    input  rmode_e         mode,
    output logic [DW-2:0]  mag,
    output logic           inexact,
    output logic           tiny
);
    localparam int EXTW  = SW + 1;
    localparam int SHMAX = SW + 2;
    localparam int SHW   = $clog2(SHMAX + 1);

    logic signed [XW-1:0] e_in;
    logic signed [XW:0]   sh_raw;
    logic [SHW-1:0]       sh;
    logic [EXTW-1:0]      ext;
    logic [2*EXTW-1:0]    wide;
    logic [SW-1:0]        mant_d;
    logic [SW-1:0]        den;
    logic                 g_d, s_d, inc, trial;

    assign e_in   = $signed(p.exp);
    assign sh_raw = $signed((XW+1)'(1)) - $signed({e_in[XW-1], e_in});

    always_comb begin
        if (sh_raw > $signed((XW+1)'(SHMAX)))
            sh = SHW'(SHMAX);
        else if (sh_raw < $signed((XW+1)'(1)))
            sh = SHW'(1);
        else
            sh = SHW'(sh_raw);
    end

    assign ext    = {p.sig, p.grd};
    assign wide   = {ext, {EXTW{1'b0}}} >> sh;
    assign mant_d = wide[2*EXTW-1:EXTW+1];
    assign g_d    = wide[EXTW];
    assign s_d    = (|wide[EXTW-1:0]) | p.stk;

    assign inexact = g_d | s_d;
    assign inc     = inexact & round_up(mode, p.sign, mant_d[0], g_d, s_d);
    assign den     = mant_d + SW'(inc);
    assign mag     = {{(EW-1){1'b0}}, den};

    // Trial rounding at the normal position decides tininess at exponent 0.
    assign trial = round_up(mode, p.sign, p.sig[0], p.grd, p.stk);
    assign tiny  = ~((e_in == XEXP_ZERO) & (p.grd | p.stk) & trial & (&p.sig));

endmodule

// File: rtl/fpm_round.sv
module fpm_round
    import fpm_pkg::*;
(
    input  fpm_prod_t p,
    input  rmode_e    mode,
    input  logic      ovf_te,
    input  logic      unf_te,
    input  logic      inx_te,
    output fpm_out_t  res
);
    logic signed [XW-1:0] e_in;
    logic signed [XW-1:0] exp_r;
    logic                 inexact0, do_rnd, inc, carry;
    logic [SW:0]          sum;
    logic [MW-1:0]        mant_r;
    logic                 ovf, unf, inf_sel, inx;
    logic [DW-2:0]        sat_mag;
    logic [DW-2:0]        dn_mag;
    logic                 dn_inexact, dn_tiny;

    assign e_in     = $signed(p.exp);
    assign inexact0 = p.grd | p.stk;
    assign do_rnd   = inexact0 & ((e_in > XEXP_ZERO) | unf_te);
    assign inc      = do_rnd & round_up(mode, p.sign, p.sig[0], p.grd, p.stk);
    assign sum      = {1'b0, p.sig} + (SW+1)'(inc);
    assign carry    = sum[SW];
    assign mant_r   = carry ? sum[SW-1:1] : sum[MW-1:0];
    assign exp_r    = e_in + $signed({{(XW-1){1'b0}}, carry});

    assign ovf = exp_r >= XEXP_TOP;
    assign unf = exp_r <= XEXP_ZERO;

    assign inf_sel = (mode == RM_NEAR) | ((mode == RM_UP) & ~p.sign) | ((mode == RM_DOWN) & p.sign);
    assign sat_mag = inf_sel ? {{EW{1'b1}}, {MW{1'b0}}}
                             : {{(EW-1){1'b1}}, 1'b0, {MW{1'b1}}};

    fpm_denorm u_denorm (
        .p       (p),
        .mode    (mode),
        .mag     (dn_mag),
        .inexact (dn_inexact),
        .tiny    (dn_tiny)
    );

    always_comb begin
        res    = '0;
        res.wr = 1'b1;
        inx    = inexact0;
        if (ovf) begin
            if (ovf_te) begin
                res.bits         = {p.sign, EW'(exp_r - XEXP_WRAP), mant_r};
                res.trap[FX_OVF] = 1'b1;
            end else begin
                res.bits         = {p.sign, sat_mag};
                res.flag[FX_OVF] = 1'b1;
                inx              = 1'b1;
            end
        end else if (unf) begin
            if (unf_te) begin
                res.bits         = {p.sign, EW'(exp_r + XEXP_WRAP), mant_r};
                res.trap[FX_UNF] = 1'b1;
            end else begin
                res.bits         = {p.sign, dn_mag};
                inx              = dn_inexact;
                res.flag[FX_UNF] = dn_inexact & dn_tiny;
            end
        end else begin
            res.bits = {p.sign, EW'(exp_r), mant_r};
        end
        if (inx) begin
            if (inx_te) res.trap[FX_INX] = 1'b1;
            else        res.flag[FX_INX] = 1'b1;
        end
    end

endmodule

// File: rtl/fpm_post.sv
module fpm_post
    import fpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid_i,
    input  logic [DW-1:0]    opa_i,
    input  logic [DW-1:0]    opb_i,
    input  logic [SW-1:0]    prod_sig_i,
    input  logic             prod_grd_i,
    input  logic             prod_stk_i,
    input  logic [XW-1:0]    prod_exp_i,
    input  logic [1:0]       rnd_mode_i,
    input  logic [FLG_W-1:0] trap_en_i,
    input  logic             flag_clr_i,
    output logic             out_valid_o,
    output logic [DW-1:0]    result_o,
    output logic             result_wr_o,
    output logic [FLG_W-1:0] trap_o,
    output logic [FLG_W-1:0] flags_o
);
    fpm_prod_t prod;
    fpm_out_t  spc_res, rnd_res, sel;
    logic      spc_hit;
    rmode_e    mode;

    assign mode      = rmode_e'(rnd_mode_i);
    assign prod.sign = opa_i[DW-1] ^ opb_i[DW-1];
    assign prod.exp  = prod_exp_i;
    assign prod.sig  = prod_sig_i;
    assign prod.grd  = prod_grd_i;
    assign prod.stk  = prod_stk_i;

    fpm_special u_special (
        .opa    (opa_i),
        .opb    (opb_i),
        .inv_te (trap_en_i[FX_INV]),
        .hit    (spc_hit),
        .res    (spc_res)
    );

    fpm_round u_round (
        .p      (prod),
        .mode   (mode),
        .ovf_te (trap_en_i[FX_OVF]),
        .unf_te (trap_en_i[FX_UNF]),
        .inx_te (trap_en_i[FX_INX]),
        .res    (rnd_res)
    );

    assign sel = spc_hit ? spc_res : rnd_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            result_o    <= '0;
            result_wr_o <= 1'b0;
            trap_o      <= '0;
            flags_o     <= '0;
        end else begin
            out_valid_o <= in_valid_i;
            result_wr_o <= in_valid_i & sel.wr;
            trap_o      <= in_valid_i ? sel.trap : '0;
            if (in_valid_i && sel.wr)
                result_o <= sel.bits;
            flags_o <= (flag_clr_i ? '0 : flags_o) | (in_valid_i ? sel.flag : '0);
        end
    end

    AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (rst) in_valid_i |=> out_valid_o); // R13
    AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (rst) !in_valid_i |=> !out_valid_o); // R13
    AST_IDLE_NO_TRAP: assert property (@(posedge clk) disable iff (rst) !out_valid_o |-> (trap_o == '0)); // R13
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst) !flag_clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R12
    AST_INV_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst) (out_valid_o && trap_o[FX_INV]) |-> !result_wr_o); // R2
    AST_RANGE_TRAP_WRITES: assert property (@(posedge clk) disable iff (rst) (out_valid_o && (trap_o[FX_OVF] || trap_o[FX_UNF])) |-> result_wr_o); // R7
    AST_ONE_RANGE_TRAP: assert property (@(posedge clk) disable iff (rst) out_valid_o |-> !(trap_o[FX_OVF] && trap_o[FX_UNF])); // R8

endmodule

// File: tb/fpm_post_bench.sv
`timescale 1ns/1ps
module fpm_post_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid_i;
    logic [63:0] opa_i, opb_i;
    logic [52:0] prod_sig_i;
    logic        prod_grd_i, prod_stk_i;
    logic [12:0] prod_exp_i;
    logic [1:0]  rnd_mode_i;
    logic [3:0]  trap_en_i;
    logic        flag_clr_i;
    logic        out_valid_o;
    logic [63:0] result_o;
    logic        result_wr_o;
    logic [3:0]  trap_o;
    logic [3:0]  flags_o;

    always #2.5 clk = ~clk;

    fpm_post u_fpm_post (
        .clk         (clk),
        .rst         (rst),
        .in_valid_i  (in_valid_i),
        .opa_i       (opa_i),
        .opb_i       (opb_i),
        .prod_sig_i  (prod_sig_i),
        .prod_grd_i  (prod_grd_i),
        .prod_stk_i  (prod_stk_i),
        .prod_exp_i  (prod_exp_i),
        .rnd_mode_i  (rnd_mode_i),
        .trap_en_i   (trap_en_i),
        .flag_clr_i  (flag_clr_i),
        .out_valid_o (out_valid_o),
        .result_o    (result_o),
        .result_wr_o (result_wr_o),
        .trap_o      (trap_o),
        .flags_o     (flags_o)
    );

    typedef struct {
        logic [63:0] bits;
        logic        wr;
        logic [3:0]  trap;
        logic [3:0]  flags;
        string       req;
    } exp_t;

    exp_t       sb_q[$];
    int         n_checks = 0;
    int         n_fail   = 0;
    logic [3:0] exp_flags = 4'h0;
    bit         done = 1'b0;

    localparam logic [52:0] H    = 53'h10_0000_0000_0000;
    localparam logic [52:0] ONES = 53'h1F_FFFF_FFFF_FFFF;
    localparam logic [63:0] P1   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] N1   = 64'hBFF0_0000_0000_0000;

    task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [52:0] sig,
                         input logic g, input logic s, input logic [12:0] e, input logic [1:0] m,
                         input logic [3:0] te, input logic [63:0] eb, input logic ew,
                         input logic [3:0] et, input logic [3:0] nf, input string req);
        exp_t it;
        @(negedge clk);
        opa_i      = a;
        opb_i      = b;
        prod_sig_i = sig;
        prod_grd_i = g;
        prod_stk_i = s;
        prod_exp_i = e;
        rnd_mode_i = m;
        trap_en_i  = te;
        flag_clr_i = 1'b0;
        in_valid_i = 1'b1;
        exp_flags  = exp_flags | nf;
        it.bits  = eb;
        it.wr    = ew;
        it.trap  = et;
        it.flags = exp_flags;
        it.req   = req;
        sb_q.push_back(it);
    endtask

    task automatic clear_flags();
        @(negedge clk);
        in_valid_i = 1'b0;
        flag_clr_i = 1'b1;
        exp_flags  = 4'h0;
        @(negedge clk);
        flag_clr_i = 1'b0;
        n_checks++;
        if (flags_o !== 4'h0) begin
            n_fail++;
            $display("FAIL R12 flags after clear: actual %h expected 0", flags_o);
        end
    endtask

    // Monitor: one check per produced result
    always @(negedge clk) begin
        if (!rst && out_valid_o && !done) begin
            exp_t it;
            n_checks++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R13 unexpected output: actual %h expected none", result_o);
            end else begin
                it = sb_q.pop_front();
                if (result_wr_o !== it.wr || trap_o !== it.trap || flags_o !== it.flags ||
                    (it.wr && result_o !== it.bits)) begin
                    n_fail++;
                    $display("FAIL %s: actual res=%h wr=%b trap=%h flags=%h expected res=%h wr=%b trap=%h flags=%h",
                             it.req, result_o, result_wr_o, trap_o, flags_o,
                             it.bits, it.wr, it.trap, it.flags);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid_i = 1'b0; flag_clr_i = 1'b0;
        opa_i = '0; opb_i = '0; prod_sig_i = '0; prod_grd_i = 1'b0; prod_stk_i = 1'b0;
        prod_exp_i = '0; rnd_mode_i = '0; trap_en_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_checks++;
        if (out_valid_o !== 1'b0 || flags_o !== 4'h0) begin
            n_fail++;
            $display("FAIL R13 reset state: actual valid=%b flags=%h expected 0 0", out_valid_o, flags_o);
        end

        // Rounding on the normal path (R1, R4, R5, R11, R13)
        drive(P1, P1, H | 53'd5, 0, 0, 13'd1023, 0, 4'h0, 64'h3FF0_0000_0000_0005, 1, 4'h0, 4'h0, "R13 exact");
        drive(P1, P1, H | 53'd4, 1, 0, 13'd1023, 0, 4'h0, 64'h3FF0_0000_0000_0004, 1, 4'h0, 4'h1, "R4 tie even");
        drive(P1, P1, H | 53'd5, 1, 0, 13'd1023, 0, 4'h0, 64'h3FF0_0000_0000_0006, 1, 4'h0, 4'h1, "R4 tie odd");
        drive(P1, P1, H | 53'd5, 1, 1, 13'd1023, 1, 4'h0, 64'h3FF0_0000_0000_0005, 1, 4'h0, 4'h1, "R4 toward zero");
        drive(N1, P1, H | 53'd5, 0, 1, 13'd1023, 2, 4'h0, 64'hBFF0_0000_0000_0005, 1, 4'h0, 4'h1, "R1 R4 up negative");
        drive(N1, P1, H | 53'd5, 0, 1, 13'd1023, 3, 4'h0, 64'hBFF0_0000_0000_0006, 1, 4'h0, 4'h1, "R4 down negative");
        drive(P1, P1, H | 53'd5, 1, 0, 13'd1023, 0, 4'h1, 64'h3FF0_0000_0000_0006, 1, 4'h1, 4'h0, "R11 inexact trap");
        drive(P1, P1, ONES, 1, 0, 13'd1023, 0, 4'h0, 64'h4000_0000_0000_0000, 1, 4'h0, 4'h1, "R5 carry");
        clear_flags();

        // Overflow (R6, R7)
        drive(P1, P1, H, 0, 0, 13'd2047, 0, 4'h0, 64'h7FF0_0000_0000_0000, 1, 4'h0, 4'h5, "R6 nearest inf");
        drive(P1, P1, H, 0, 0, 13'd2047, 1, 4'h0, 64'h7FEF_FFFF_FFFF_FFFF, 1, 4'h0, 4'h5, "R6 zero max");
        drive(N1, P1, H, 0, 0, 13'd2047, 2, 4'h0, 64'hFFEF_FFFF_FFFF_FFFF, 1, 4'h0, 4'h5, "R6 up negative max");
        drive(P1, P1, ONES, 1, 0, 13'd2046, 0, 4'h0, 64'h7FF0_0000_0000_0000, 1, 4'h0, 4'h5, "R5 R6 carry to overflow");
        clear_flags();
        drive(P1, P1, H | 53'd3, 0, 0, 13'd2050, 0, 4'h4, 64'h2020_0000_0000_0003, 1, 4'h4, 4'h0, "R7 wrap");
        drive(P1, P1, H | 53'd3, 1, 0, 13'd2050, 0, 4'h5, 64'h2020_0000_0000_0004, 1, 4'h5, 4'h0, "R7 R11 wrap inexact trap");
        drive(P1, P1, H | 53'd3, 1, 0, 13'd2050, 0, 4'h4, 64'h2020_0000_0000_0004, 1, 4'h4, 4'h1, "R7 R11 wrap inexact flag");
        drive(P1, P1, H | 53'd1, 0, 0, 13'h1FF6, 0, 4'h2, 64'h5F60_0000_0000_0001, 1, 4'h2, 4'h0, "R8 wrap");
        clear_flags();

        // Underflow without trap (R9, R10)
        drive(P1, P1, H, 0, 0, 13'd0, 0, 4'h0, 64'h0008_0000_0000_0000, 1, 4'h0, 4'h0, "R9 R10 exact denormal");
        drive(P1, P1, H | 53'd3, 0, 0, 13'h1FFF, 0, 4'h0, 64'h0004_0000_0000_0001, 1, 4'h0, 4'h3, "R9 shift two");
        clear_flags();
        drive(P1, P1, ONES, 1, 0, 13'd0, 0, 4'h0, 64'h0010_0000_0000_0000, 1, 4'h0, 4'h1, "R10 not tiny");
        drive(P1, P1, ONES, 0, 1, 13'd0, 0, 4'h0, 64'h0010_0000_0000_0000, 1, 4'h0, 4'h3, "R10 tiny");
        drive(N1, P1, H, 0, 0, 13'h1F9C, 1, 4'h0, 64'h8000_0000_0000_0000, 1, 4'h0, 4'h3, "R9 deep shift");
        clear_flags();

        // Special operands (R1, R2, R3, R13)
        drive(64'h7FF0_0000_0000_0000, 64'h0, H, 0, 0, 13'd0, 0, 4'h0, 64'h7FF8_0000_0000_0000, 1, 4'h0, 4'h8, "R2 inf times zero");
        drive(64'h7FF0_0000_0000_0000, 64'h0, H, 0, 0, 13'd0, 0, 4'h8, 64'h0, 0, 4'h8, 4'h0, "R2 invalid trap");
        drive(64'h8000_0000_0000_0000, 64'h7FF0_0000_0000_0000, H, 0, 0, 13'd0, 0, 4'h0, 64'h7FF8_0000_0000_0000, 1, 4'h0, 4'h8, "R2 zero times inf");
        clear_flags();
        drive(64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0002, H, 0, 0, 13'd0, 0, 4'h0, 64'h7FF8_0000_0000_0001, 1, 4'h0, 4'h8, "R3 snan a");
        drive(64'h7FF8_0000_0000_0003, 64'hFFF0_0000_0000_0004, H, 0, 0, 13'd0, 0, 4'h0, 64'hFFF8_0000_0000_0004, 1, 4'h0, 4'h8, "R3 snan b");
        clear_flags();
        drive(64'h7FF8_0000_0000_0003, 64'h7FF8_0000_0000_0005, H, 0, 0, 13'd0, 0, 4'h0, 64'h7FF8_0000_0000_0003, 1, 4'h0, 4'h0, "R3 quiet pair");
        drive(64'h7FF0_0000_0000_0000, 64'h7FF8_0000_0000_0007, H, 0, 0, 13'd0, 0, 4'h0, 64'h7FF8_0000_0000_0007, 1, 4'h0, 4'h0, "R3 inf times nan");
        drive(64'h7FF0_0000_0000_0001, P1, H, 0, 0, 13'd0, 0, 4'h8, 64'h0, 0, 4'h8, 4'h0, "R3 snan trap");
        drive(64'h7FF0_0000_0000_0000, 64'hC000_0000_0000_0000, H, 0, 0, 13'd0, 0, 4'h0, 64'hFFF0_0000_0000_0000, 1, 4'h0, 4'h0, "R1 signed inf");
        drive(64'h8000_0000_0000_0000, P1, H | 53'd5, 1, 1, 13'd2047, 0, 4'h0, 64'h8000_0000_0000_0000, 1, 4'h0, 4'h0, "R1 R13 zero ignores product");

        @(negedge clk);
        in_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        n_checks++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R13 missing results: actual %0d pending expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule